// File: doc/BRIEF.md
# PLL Rate Table Lookup Engine

This block keeps a small table of the output rates a clock generator can produce. Each row holds the rate itself and the four settings that produce it: reference divider, output divider, feedback multiplier and loop bandwidth trim. Rows are written through a plain indexed write port. The rows must be kept in strictly non-increasing rate order, and the first row whose rate is zero ends the list.

A query is started with a one-cycle start pulse and runs in one of two modes. An exact query looks for a row whose rate equals the request. A rounding query looks for the largest supported rate that does not exceed the request. The search walks the table one row per clock. It stops at the first terminator row or at the last row of the table, whichever comes first. The result appears together with a one-cycle done pulse and stays on the outputs until the next done.

Top module: `pll_rate_lookup`

## Requirements
- R1: After reset, busy, done, hit and err are low, all result outputs are zero and every table row has rate zero, so the table is empty.
- R2: A cycle with `tbl_wr_en` high stores the five write fields into row `tbl_wr_idx`. Later queries see the new row.
- R3: An exact query (`q_round`=0) returns the first row, scanning from index 0, whose rate equals `q_rate`. It returns that row's five fields with hit=1. If that row is at index k, done rises k+1 cycles after the clock edge that accepted the start.
- R4: An exact query that meets a zero-rate row at index k, or scans all DEPTH rows without a match (k=DEPTH-1), ends with hit=0, err=0 and all result fields zero. Done comes k+1 cycles after the start.
- R5: A rounding query (`q_round`=1) returns the first row at index k whose rate is less than or equal to `q_rate`, with hit=1. Done comes k+1 cycles after the start.
- R6: A rounding query whose request is below every valid row returns the last valid row with hit=0 and err=0. If a zero-rate row at index k ends the list, the row returned is at index k-1 and done comes k+1 cycles after the start. If the whole table is valid, row DEPTH-1 is returned and done comes DEPTH cycles after the start.
- R7: With an empty table (row 0 has rate zero), an exact query ends as a miss and a rounding query ends with err=1, hit=0 and all result fields zero. Both complete one cycle after the start.
- R8: busy is high from the cycle after an accepted start up to the done cycle. done is a single-cycle pulse, and busy is low while done is high.
- R9: A start pulse while busy is high is ignored. The search in progress completes with its own mode, request and timing.
- R10: hit, err and the result fields change only in a cycle where done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_wr_en | input | 1 | Row write strobe |
| tbl_wr_idx | input | IDX_W | Row index to write |
| tbl_wr_rate | input | RATE_W | Rate of the row written (zero marks end of list) |
| tbl_wr_refdiv | input | REF_W | Reference divider of the row written |
| tbl_wr_outdiv | input | OD_W | Output divider of the row written |
| tbl_wr_fbmul | input | FB_W | Feedback multiplier of the row written |
| tbl_wr_bwadj | input | BW_W | Bandwidth trim of the row written |
| q_start | input | 1 | Start pulse for a query |
| q_round | input | 1 | Query mode: 0 exact, 1 rounding |
| q_rate | input | RATE_W | Requested rate |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when a result is ready |
| hit | output | 1 | Exact match found, or a fitting row found while rounding |
| err | output | 1 | Rounding query on an empty table |
| r_rate | output | RATE_W | Rate of the returned row |
| r_refdiv | output | REF_W | Reference divider of the returned row |
| r_outdiv | output | OD_W | Output divider of the returned row |
| r_fbmul | output | FB_W | Feedback multiplier of the returned row |
| r_bwadj | output | BW_W | Bandwidth trim of the returned row |

## Verification
The bench builds the block with DEPTH=8 and default field widths. With this depth the bench can fill every row without a terminator and reach the path that ends at the depth limit. That path covers both the miss at the last index and the clamp to row DEPTH-1.

The bench also loads a partial table that contains a duplicated rate. This brings in first-match ordering, the clamp to the row before a terminator, and a start pulse arriving mid-search. The empty table after reset covers the error path, where the search ends on its first cycle.

// File: rtl/rate_lookup_pkg.sv
// Package: shared type definitions for the rate lookup engine.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package rate_lookup_pkg;

    // Scan controller state
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_t;

    // Query mode as driven on the q_round pin
    typedef enum logic [0:0] {
        QM_EXACT = 1'b0,
        QM_ROUND = 1'b1
    } query_mode_t;

endpackage

// File: rtl/rate_table_store.sv
// Module: rate_table_store
// Holds DEPTH rows of packed entries. Rows are written through one indexed
// write port and read combinationally through one index.
// Assumes: the entry rate sits in the top RATE_W bits of a row. All rows
// clear to zero on reset, which leaves the table empty.
module rate_table_store #(
    parameter int DEPTH   = 16,
    parameter int ENTRY_W = 67,
    parameter int IDX_W   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [ENTRY_W-1:0] rd_data
);

    logic [ENTRY_W-1:0] rows [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_row
            // Per-row storage: clear on reset, load when this row is addressed
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rows[g] <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    rows[g] <= wr_data;
                end
            end
        end
    endgenerate

    // Read port: select the row under scan
    always_comb begin
        rd_data = rows[rd_idx];
    end

endmodule

// File: rtl/rate_entry_cmp.sv
// Module: rate_entry_cmp
// Compares one row's rate with the captured request. It reports whether the
// row ends the list, matches exactly, or fits under the request.
// Assumes: unsigned rates, and a zero rate means end of list.
module rate_entry_cmp #(
    parameter int RATE_W = 32
) (
    input  logic [RATE_W-1:0] row_rate,
    input  logic [RATE_W-1:0] want_rate,
    output logic              is_end,
    output logic              is_eq,
    output logic              is_le
);

    // Relational decode of the current row against the request
    always_comb begin
        is_end = (row_rate == '0);
        is_eq  = (row_rate == want_rate);
        is_le  = (row_rate <= want_rate);
    end

endmodule

// File: rtl/rate_scan_ctrl.sv
// Module: rate_scan_ctrl
// Sequences one query over the table, one row per clock. It keeps the previous
// row so that a rounding query can clamp to it, and registers the result,
// which is shown with a one-cycle done pulse.
// Assumes: rows are in non-increasing rate order. A start pulse is only taken
// while idle.
module rate_scan_ctrl
    import rate_lookup_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int RATE_W  = 32,
    parameter int ENTRY_W = 67,
    parameter int IDX_W   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               round_mode,
    input  logic [RATE_W-1:0]  req_rate,
    input  logic [ENTRY_W-1:0] row,
    output logic [IDX_W-1:0]   rd_idx,
    output logic               busy,
    output logic               done,
    output logic               hit,
    output logic               err,
    output logic [ENTRY_W-1:0] res
);

    localparam int            RATE_LSB = ENTRY_W - RATE_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    scan_state_t        state_q;
    logic [IDX_W-1:0]   idx_q;
    logic [RATE_W-1:0]  req_q;
    query_mode_t        mode_q;
    logic [ENTRY_W-1:0] prev_q;
    logic               done_q, hit_q, err_q;
    logic [ENTRY_W-1:0] res_q;

    logic               row_end, row_eq, row_le;
    logic               at_last, at_first;
    logic               fin;
    logic               fin_hit, fin_err;
    logic [ENTRY_W-1:0] fin_res;

    rate_entry_cmp #(.RATE_W(RATE_W)) u_cmp (
        .row_rate  (row[ENTRY_W-1:RATE_LSB]),
        .want_rate (req_q),
        .is_end    (row_end),
        .is_eq     (row_eq),
        .is_le     (row_le)
    );

    // Position flags for the row under scan
    always_comb begin
        at_last  = (idx_q == LAST_IDX);
        at_first = (idx_q == '0);
    end

    // Decide whether this row ends the search, and with which result
    always_comb begin
        fin     = 1'b0;
        fin_hit = 1'b0;
        fin_err = 1'b0;
        fin_res = '0;
        if (mode_q == QM_EXACT) begin
            if (row_end) begin
                fin = 1'b1;
            end else if (row_eq) begin
                fin     = 1'b1;
                fin_hit = 1'b1;
                fin_res = row;
            end else if (at_last) begin
                fin = 1'b1;
            end
        end else begin
            if (row_end) begin
                fin = 1'b1;
                if (at_first) begin
                    fin_err = 1'b1;
                end else begin
                    fin_res = prev_q;
                end
            end else if (row_le) begin
                fin     = 1'b1;
                fin_hit = 1'b1;
                fin_res = row;
            end else if (at_last) begin
                fin     = 1'b1;
                fin_res = row;
            end
        end
    end

    // Control state: accept a query, step through rows, latch the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            req_q   <= '0;
            mode_q  <= QM_EXACT;
            prev_q  <= '0;
            done_q  <= 1'b0;
            hit_q   <= 1'b0;
            err_q   <= 1'b0;
            res_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_SCAN;
                        idx_q   <= '0;
                        req_q   <= req_rate;
                        mode_q  <= query_mode_t'(round_mode);
                        prev_q  <= '0;
                    end
                end
                ST_SCAN: begin
                    if (fin) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        hit_q   <= fin_hit;
                        err_q   <= fin_err;
                        res_q   <= fin_res;
                    end else begin
                        idx_q  <= idx_q + IDX_W'(1);
                        prev_q <= row;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output drive
    always_comb begin
        rd_idx = idx_q;
        busy   = (state_q == ST_SCAN);
        done   = done_q;
        hit    = hit_q;
        err    = err_q;
        res    = res_q;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(req_q) && $stable(mode_q))); // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({hit, err, res})); // R10
    AST_ERR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!hit && res == '0)); // R7
    AST_HIT_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && err)); // R5

endmodule

// File: rtl/pll_rate_lookup.sv
// Module: pll_rate_lookup
// Top level of the rate table lookup engine. It packs the write fields into a
// row, keeps the rows in a store and runs exact or rounding searches through
// the scan controller.
// Assumes: software keeps rows in non-increasing rate order with a zero-rate
// terminator, and does not write rows during a search.
module pll_rate_lookup #(
    parameter int DEPTH  = 16,
    parameter int RATE_W = 32,
    parameter int REF_W  = 6,
    parameter int OD_W   = 4,
    parameter int FB_W   = 13,
    parameter int BW_W   = 12,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_wr_en,
    input  logic [IDX_W-1:0]  tbl_wr_idx,
    input  logic [RATE_W-1:0] tbl_wr_rate,
    input  logic [REF_W-1:0]  tbl_wr_refdiv,
    input  logic [OD_W-1:0]   tbl_wr_outdiv,
    input  logic [FB_W-1:0]   tbl_wr_fbmul,
    input  logic [BW_W-1:0]   tbl_wr_bwadj,
    input  logic              q_start,
    input  logic              q_round,
    input  logic [RATE_W-1:0] q_rate,
    output logic              busy,
    output logic              done,
    output logic              hit,
    output logic              err,
    output logic [RATE_W-1:0] r_rate,
    output logic [REF_W-1:0]  r_refdiv,
    output logic [OD_W-1:0]   r_outdiv,
    output logic [FB_W-1:0]   r_fbmul,
    output logic [BW_W-1:0]   r_bwadj
);

    localparam int ENTRY_W = RATE_W + REF_W + OD_W + FB_W + BW_W;

    logic [ENTRY_W-1:0] wr_row;
    logic [ENTRY_W-1:0] rd_row;
    logic [ENTRY_W-1:0] res_row;
    logic [IDX_W-1:0]   scan_idx;

    // Row packing: rate in the top bits, then the four settings
    always_comb begin
        wr_row = {tbl_wr_rate, tbl_wr_refdiv, tbl_wr_outdiv, tbl_wr_fbmul, tbl_wr_bwadj};
    end

    rate_table_store #(
        .DEPTH   (DEPTH),
        .ENTRY_W (ENTRY_W),
        .IDX_W   (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr_en),
        .wr_idx  (tbl_wr_idx),
        .wr_data (wr_row),
        .rd_idx  (scan_idx),
        .rd_data (rd_row)
    );

    rate_scan_ctrl #(
        .DEPTH   (DEPTH),
        .RATE_W  (RATE_W),
        .ENTRY_W (ENTRY_W),
        .IDX_W   (IDX_W)
    ) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (q_start),
        .round_mode (q_round),
        .req_rate   (q_rate),
        .row        (rd_row),
        .rd_idx     (scan_idx),
        .busy       (busy),
        .done       (done),
        .hit        (hit),
        .err        (err),
        .res        (res_row)
    );

    // Result unpacking back into named fields
    always_comb begin
        {r_rate, r_refdiv, r_outdiv, r_fbmul, r_bwadj} = res_row;
    end

endmodule

// File: tb/sim_pll_rate_lookup.sv
module sim_pll_rate_lookup;

    localparam int D      = 8;
    localparam int IW     = $clog2(D);
    localparam int RATE_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tbl_wr_en = 1'b0;
    logic [IW-1:0] tbl_wr_idx = '0;
    logic [31:0] tbl_wr_rate = '0;
    logic [5:0]  tbl_wr_refdiv = '0;
    logic [3:0]  tbl_wr_outdiv = '0;
    logic [12:0] tbl_wr_fbmul = '0;
    logic [11:0] tbl_wr_bwadj = '0;
    logic q_start = 1'b0;
    logic q_round = 1'b0;
    logic [31:0] q_rate = '0;
    logic busy, done, hit, err;
    logic [31:0] r_rate;
    logic [5:0]  r_refdiv;
    logic [3:0]  r_outdiv;
    logic [12:0] r_fbmul;
    logic [11:0] r_bwadj;

    always #4 clk = ~clk;

    pll_rate_lookup #(.DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_rate(tbl_wr_rate),
        .tbl_wr_refdiv(tbl_wr_refdiv), .tbl_wr_outdiv(tbl_wr_outdiv),
        .tbl_wr_fbmul(tbl_wr_fbmul), .tbl_wr_bwadj(tbl_wr_bwadj),
        .q_start(q_start), .q_round(q_round), .q_rate(q_rate),
        .busy(busy), .done(done), .hit(hit), .err(err),
        .r_rate(r_rate), .r_refdiv(r_refdiv), .r_outdiv(r_outdiv),
        .r_fbmul(r_fbmul), .r_bwadj(r_bwadj)
    );

    int total = 0;
    int bad = 0;
    string cur_tag = "R1";
    bit cmp_en = 1'b0;

    // Behavioural reference model state
    logic [31:0] t_rate [D];
    int t_ref [D], t_od [D], t_fb [D], t_bw [D];
    bit m_busy, m_done, m_hit, m_err;
    int m_cnt;
    longint m_rate, m_ref, m_od, m_fb, m_bw;
    bit p_hit, p_err;
    longint p_rate, p_ref, p_od, p_fb, p_bw;

    task automatic take_row(input int i);
        p_rate = t_rate[i]; p_ref = t_ref[i]; p_od = t_od[i];
        p_fb = t_fb[i]; p_bw = t_bw[i];
    endtask

    task automatic model_query(input bit rnd, input logic [31:0] req);
        int k;
        bit stop;
        k = D - 1;
        stop = 1'b0;
        p_hit = 0; p_err = 0;
        p_rate = 0; p_ref = 0; p_od = 0; p_fb = 0; p_bw = 0;
        for (int i = 0; i < D && !stop; i++) begin
            if (t_rate[i] == 0) begin
                k = i; stop = 1'b1;
                if (rnd) begin
                    if (i == 0) p_err = 1;
                    else take_row(i - 1);
                end
            end else if ((!rnd && t_rate[i] == req) || (rnd && t_rate[i] <= req)) begin
                k = i; stop = 1'b1; p_hit = 1; take_row(i);
            end
        end
        if (!stop && rnd) take_row(D - 1);
        m_cnt = k + 1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_cnt = 0; m_hit = 0; m_err = 0;
            m_rate = 0; m_ref = 0; m_od = 0; m_fb = 0; m_bw = 0;
            for (int i = 0; i < D; i++) begin
                t_rate[i] = 0; t_ref[i] = 0; t_od[i] = 0; t_fb[i] = 0; t_bw[i] = 0;
            end
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 0; m_done = 1; m_hit = p_hit; m_err = p_err;
                    m_rate = p_rate; m_ref = p_ref; m_od = p_od; m_fb = p_fb; m_bw = p_bw;
                end
            end else if (q_start) begin
                model_query(q_round, q_rate);
                m_busy = 1;
            end
            if (tbl_wr_en) begin
                t_rate[tbl_wr_idx] = tbl_wr_rate; t_ref[tbl_wr_idx] = tbl_wr_refdiv;
                t_od[tbl_wr_idx] = tbl_wr_outdiv; t_fb[tbl_wr_idx] = tbl_wr_fbmul;
                t_bw[tbl_wr_idx] = tbl_wr_bwadj;
            end
        end
    end

    task automatic check(input string tag, input string name, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, name, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            string t;
            t = m_done ? cur_tag : "R10";
            if (!rst_n) t = "R1";
            check((rst_n ? "R8" : "R1"), "busy", busy, m_busy);
            check((rst_n ? "R8" : "R1"), "done", done, m_done);
            check(t, "hit", hit, m_hit);
            check(t, "err", err, m_err);
            check(t, "rate", r_rate, m_rate);
            check(t, "refdiv", r_refdiv, m_ref);
            check(t, "outdiv", r_outdiv, m_od);
            check(t, "fbmul", r_fbmul, m_fb);
            check(t, "bwadj", r_bwadj, m_bw);
        end
    end

    task automatic put_row(input int i, input int rate, input int rf, input int od, input int fb, input int bw);
        @(negedge clk);
        tbl_wr_en = 1; tbl_wr_idx = IW'(i); tbl_wr_rate = rate;
        tbl_wr_refdiv = 6'(rf); tbl_wr_outdiv = 4'(od); tbl_wr_fbmul = 13'(fb); tbl_wr_bwadj = 12'(bw);
        @(negedge clk);
        tbl_wr_en = 0;
    endtask

    task automatic query(input bit rnd, input int req, input string tag);
        @(negedge clk);
        cur_tag = tag;
        q_start = 1; q_round = rnd; q_rate = req;
        @(negedge clk);
        q_start = 0;
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 20000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        cmp_en = 1;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R7: empty table after reset
        query(0, 1000, "R7");
        query(1, 1000, "R7");
        // R2: load a descending table with a duplicated rate and a terminator
        put_row(0, 1200, 1, 1, 99, 50);
        put_row(1, 1000, 2, 2, 166, 83);
        put_row(2, 800, 3, 1, 99, 49);
        put_row(3, 600, 1, 4, 199, 100);
        put_row(4, 600, 2, 2, 99, 12);
        put_row(5, 400, 1, 2, 33, 16);
        query(0, 800, "R2/R3");
        query(0, 1200, "R3");
        query(0, 600, "R3");
        query(0, 400, "R3");
        query(0, 700, "R4");
        query(1, 900, "R5");
        query(1, 1000, "R5");
        query(1, 650, "R5");
        query(1, 5000, "R5");
        query(1, 100, "R6");
        // R9: start pulse mid-search is ignored
        @(negedge clk);
        cur_tag = "R9";
        q_start = 1; q_round = 0; q_rate = 400;
        @(negedge clk);
        q_start = 0;
        @(negedge clk);
        q_start = 1; q_round = 1; q_rate = 5000;
        @(negedge clk);
        q_start = 0;
        while (m_busy) @(negedge clk);
        @(negedge clk);
        // Full table with no terminator: depth limit paths
        put_row(6, 300, 4, 3, 63, 31);
        put_row(7, 200, 5, 3, 41, 20);
        query(0, 250, "R4");
        query(1, 50, "R6");
        query(1, 200, "R5");
        query(0, 200, "R3");
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule